// File: doc/BRIEF.md
# Single-bit Hamming sector ECC corrector

This block protects one NAND data sector with a Hamming-style code. It takes the sector as a stream of bytes, one per accepted cycle, and folds each byte into a parity accumulator. In write mode the sector's code is ready when the last data byte has been taken. The code is bitwise inverted, so a fully erased sector carries an all-ones code. It is presented as three bytes, least significant first, for the host to place in the spare area.

In read mode the same stream is followed by the three stored code bytes. The block compares the recomputed code with the stored one and classifies the sector into one of four cases:

- clean;
- a single flipped data bit, reported by byte offset and bit index so that the host can invert it;
- a single flipped bit inside the stored code, which needs no data repair;
- uncorrectable.

A start strobe clears the accumulator and selects the mode for the next sector. A one-cycle done pulse marks the moment the result is valid.

Top module: `sector_hamming_ecc`

## Requirements
- R1: Every set data bit has a 12-bit address {byte index, bit index}. The raw high half is the XOR of these addresses and the raw low half is the XOR of their complements. `code_bytes` is the inverse of {high, low}, and it holds code byte 0 in bits [7:0], byte 1 in [15:8] and byte 2 in [23:16].
- R2: A sector of all-ones bytes yields `code_bytes` = 24'hFFFFFF. Read back with stored bytes FF FF FF, it reports status 0.
- R3: A `start` pulse clears the accumulator and the byte count, whatever was in progress. In the next cycle `code_bytes` reads 24'hFFFFFF, `status` reads 0 and `done` is low. The same holds after reset.
- R4: In write mode (`rd_mode` low at `start`), `done` is high for exactly one cycle. That cycle follows the clock edge that accepts the last data byte.
- R5: In read mode the three stored code bytes follow the data bytes, byte 0 first. `done` pulses for one cycle after the edge that accepts the third of them.
- R6: The check word is the XOR of the computed and stored codes. When it is zero, `status` is 0 (clean).
- R7: When the two 12-bit halves of the check word XOR to 12'hFFF and check[23:15] is below the sector size, `status` is 1. `err_byte` is then check[23:15] and `err_bit` is check[14:12].
- R8: A check word with exactly one bit set gives `status` 2: the stored code is damaged and the data is good.
- R9: Every other nonzero check word gives `status` 3. This includes the case of R7 with an offset at or beyond the sector size.
- R10: Once a sector's bytes are complete, further valid bytes before the next `start` are ignored. `code_bytes` is unchanged and no `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear accumulator and begin a sector |
| rd_mode | input | 1 | Sampled at start: 1 = check, 0 = generate |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Data byte, or stored code byte in read mode |
| done | output | 1 | One-cycle pulse when the result is valid |
| code_bytes | output | 24 | Computed inverted code, byte 0 in bits [7:0] |
| status | output | 2 | 0 clean, 1 data bit fixable, 2 code-only error, 3 uncorrectable |
| err_byte | output | 9 | Byte offset of the faulty data bit |
| err_bit | output | 3 | Bit index of the faulty data bit |

## Verification
The in-module assertions check these properties on every cycle:
- a start always leaves a blank accumulator and a clean status;
- done never lasts more than one cycle and always follows an accepted byte;
- excess bytes leave the code unchanged;
- a clean verdict only ever comes with matching codes.

Only the bench's scenarios can show the following:
- the exact parity values;
- the stored-byte order;
- that flipped data bits are located at the right offset and bit;
- that single code-bit damage, double errors and out-of-range offsets fall into the right class.

The bench runs with a non-power-of-two sector size so that the out-of-range offset is reachable.

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              rd_mode,
  input  logic                              in_valid,
  input  logic [7:0]                        in_byte,
  output logic                              done,
  output logic [2*($clog2(SECTOR_BYTES)+3)-1:0] code_bytes,
  output logic [1:0]                        status,
  output logic [$clog2(SECTOR_BYTES)-1:0]   err_byte,
  output logic [2:0]                        err_bit
);
  localparam int OFF_W = $clog2(SECTOR_BYTES);
  localparam int AW    = OFF_W + 3;
  localparam int CW    = 2 * AW;
  localparam int CB    = (CW + 7) / 8;
  localparam int CNT_W = $clog2(SECTOR_BYTES + CB + 1);
  localparam logic [CNT_W-1:0] N_DATA = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] N_ALL  = CNT_W'(SECTOR_BYTES + CB);
  localparam logic [OFF_W:0]   SEC_LIM = (OFF_W+1)'(SECTOR_BYTES);

  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_DATA  = 2'd1;
  localparam logic [1:0] ST_CODE  = 2'd2;
  localparam logic [1:0] ST_BAD   = 2'd3;

  logic             rd_q;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    hi_acc;
  logic             par_acc;
  logic [CB*8-1:0]  stored;

  wire [CNT_W-1:0] limit   = rd_q ? N_ALL : N_DATA;
  wire             take    = in_valid && (cnt < limit);
  wire             in_data = cnt < N_DATA;
  wire [CNT_W-1:0] sidx    = cnt - N_DATA;

  wire       bpar = ^in_byte;
  wire [2:0] colx = {^in_byte[7:4],
                     in_byte[2] ^ in_byte[3] ^ in_byte[6] ^ in_byte[7],
                     in_byte[1] ^ in_byte[3] ^ in_byte[5] ^ in_byte[7]};
  wire [AW-1:0] contrib = {bpar ? cnt[OFF_W-1:0] : {OFF_W{1'b0}}, colx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      cnt     <= '0;
      hi_acc  <= '0;
      par_acc <= 1'b0;
      stored  <= '1;
      done    <= 1'b0;
    end else if (start) begin
      rd_q    <= rd_mode;
      cnt     <= '0;
      hi_acc  <= '0;
      par_acc <= 1'b0;
      stored  <= '1;
      done    <= 1'b0;
    end else begin
      done <= take && (cnt == limit - 1'b1);
      if (take) begin
        cnt <= cnt + 1'b1;
        if (in_data) begin
          hi_acc  <= hi_acc ^ contrib;
          par_acc <= par_acc ^ bpar;
        end else begin
          for (int k = 0; k < CB; k++)
            if (sidx == CNT_W'(k)) stored[8*k +: 8] <= in_byte;
        end
      end
    end
  end

  assign code_bytes = ~{hi_acc, hi_acc ^ {AW{par_acc}}};

  wire [CW-1:0] check   = code_bytes ^ stored[CW-1:0];
  wire [AW-1:0] halves  = check[AW-1:0] ^ check[CW-1:AW];
  wire [OFF_W-1:0] off  = check[CW-1:AW+3];

  assign err_byte = off;
  assign err_bit  = check[AW+2:AW];

  always_comb begin
    if (check == '0)                 status = ST_CLEAN;
    else if (halves == '1)           status = ({1'b0, off} < SEC_LIM) ? ST_DATA : ST_BAD;
    else if ($onehot(check))         status = ST_CODE;
    else                             status = ST_BAD;
  end

  // R3
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (code_bytes == '1 && status == ST_CLEAN && !done));
  // R4, R5
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));
  // R10
  p_ignore_extra_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == limit && !start) |=> $stable(code_bytes));
  // R6
  p_clean_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_q && status == ST_CLEAN) |-> code_bytes == stored[CW-1:0]);
endmodule

// File: tb/sector_hamming_ecc_test.sv
module sector_hamming_ecc_test;
  localparam int SECT = 384;
  localparam int NV = 8;
  localparam logic [7:0]  V_SEED [NV] = '{8'd3, 8'd7, 8'd11, 8'd19, 8'd23, 8'd29, 8'd31, 8'd37};
  localparam logic        V_FLIP [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [8:0]  V_FBYT [NV] = '{9'd0, 9'd0, 9'd383, 9'd200, 9'd0, 9'd0, 9'd0, 9'd0};
  localparam logic [2:0]  V_FBIT [NV] = '{3'd0, 3'd0, 3'd7, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0};
  localparam logic [23:0] V_XOR  [NV] = '{24'h0, 24'h0, 24'h0, 24'h0,
                                          24'h000400, 24'h800000, 24'h000003, 24'hC003FF};
  localparam logic [1:0]  V_EXP  [NV] = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_mode = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic done;
  logic [23:0] code_bytes;
  logic [1:0] status;
  logic [8:0] err_byte;
  logic [2:0] err_bit;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] sec_data [SECT];

  sector_hamming_ecc #(.SECTOR_BYTES(SECT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .in_valid(in_valid), .in_byte(in_byte), .done(done),
    .code_bytes(code_bytes), .status(status), .err_byte(err_byte), .err_bit(err_bit));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code();
    logic [11:0] hi = '0, lo = '0;
    for (int i = 0; i < SECT; i++)
      for (int b = 0; b < 8; b++)
        if (sec_data[i][b]) begin
          hi ^= {i[8:0], b[2:0]};
          lo ^= ~{i[8:0], b[2:0]};
        end
    return ~{hi, lo};
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_start(input logic rd);
    @(negedge clk);
    in_valid = 1'b0;
    start = 1'b1;
    rd_mode = rd;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_sector(input logic rd, input logic [23:0] st_code, input string tag,
                            output logic [23:0] c, output logic [1:0] s,
                            output logic [8:0] eb, output logic [2:0] ebit);
    pulse_start(rd);
    for (int i = 0; i < SECT; i++) send(sec_data[i]);
    if (rd) for (int k = 0; k < 3; k++) send(st_code[8*k +: 8]);
    chk({tag, " done rises (R4/R5)"}, done, 1);
    c = code_bytes; s = status; eb = err_byte; ebit = err_bit;
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk({tag, " done one cycle R4"}, done, 0);
  endtask

  initial begin
    logic [23:0] c, wc;
    logic [1:0] s;
    logic [8:0] eb;
    logic [2:0] ebit;
    repeat (3) @(posedge clk);
    #1;
    chk("reset code R3", code_bytes, 24'hFFFFFF);
    chk("reset status R3", status, 0);
    chk("reset done R3", done, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < SECT; i++)
        sec_data[i] = 8'(i * V_SEED[v] + 7 * V_SEED[v]) ^ 8'(i >> 2);
      run_sector(1'b0, 24'h0, "write", wc, s, eb, ebit);
      chk("write code R1", wc, ref_code());
      if (V_FLIP[v]) sec_data[V_FBYT[v]][V_FBIT[v]] = ~sec_data[V_FBYT[v]][V_FBIT[v]];
      run_sector(1'b1, wc ^ V_XOR[v], "read", c, s, eb, ebit);
      case (V_EXP[v])
        2'd0: chk("clean status R6 R5", s, 0);
        2'd1: begin
          chk("data error status R7", s, 1);
          chk("err_byte R7", eb, V_FBYT[v]);
          chk("err_bit R7", ebit, V_FBIT[v]);
        end
        2'd2: chk("code-only status R8", s, 2);
        default: chk("uncorrectable status R9", s, 3);
      endcase
    end

    for (int i = 0; i < SECT; i++) sec_data[i] = 8'hFF;
    run_sector(1'b0, 24'h0, "erased", c, s, eb, ebit);
    chk("erased code R2", c, 24'hFFFFFF);
    run_sector(1'b1, 24'hFFFFFF, "erased rd", c, s, eb, ebit);
    chk("erased status R2", s, 0);

    for (int i = 0; i < SECT; i++) sec_data[i] = 8'(i * 5 + 1);
    run_sector(1'b0, 24'h0, "extra", wc, s, eb, ebit);
    send(8'h5A);
    chk("extra byte no done R10", done, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("extra byte code R10", code_bytes, wc);

    pulse_start(1'b0);
    for (int i = 0; i < 17; i++) send(8'hC3);
    pulse_start(1'b0);
    #1;
    chk("start clears code R3", code_bytes, 24'hFFFFFF);
    chk("start clears status R3", status, 0);
    run_sector(1'b0, 24'h0, "restart", c, s, eb, ebit);
    chk("restart code R3 R1", c, ref_code());

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule